// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits on the host side of an asynchronous DRAM and owns two duties that the normal access controller does not: bringing the memory out of power-up and keeping its rows refreshed. After reset it holds the strobes idle for a programmable pause. It then runs a fixed number of wake-up strobe cycles. From then on it raises refresh work at an even rate, so that every row is covered within the retention period. Each refresh is a column-strobe-first cycle: the memory's internal row counter supplies the row, so no address is needed and no data moves.

The sequencer shares the strobe pins with the access controller through a request/grant pair. It raises `ref_req` while it has work owed. It starts a cycle only on an edge where `ref_gnt` is high. Once a cycle has started it always runs to the end. Refreshes that are owed while the grant is withheld are counted. When the count reaches a limit, the retention deadline is treated as missed. The sequencer then pulses `miss`, drops `ready` and replays the whole wake-up sequence before normal operation resumes.

The clock frequency and all delays are parameters given in MHz, microseconds and nanoseconds. The block converts them to clock cycles, rounding each strobe delay up and the refresh interval down.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held, and afterwards until the pause has elapsed, `ras_n` is 1, `cas_n` is 2'b11 and `ready`, `ref_req` and `miss` are 0. `ref_req` first rises exactly PAUSE_US*CLK_MHZ clock edges after reset is released.
- R2: After the pause, exactly WAKE_COUNT strobe cycles are issued before `ready` first rises. `ready` stays 0 until the last of them has ended.
- R3: While `ready` is 1, one refresh is owed every RETENTION_US*CLK_MHZ/ROWS cycles (integer division). With the grant held high, successive row-strobe falls are exactly that many cycles apart.
- R4: In every cycle both bits of `cas_n` fall together and stay low for ceil(T_CSR_NS*CLK_MHZ/1000) cycles before `ras_n` falls. They stay low for ceil(T_CHR_NS*CLK_MHZ/1000) cycles counted from that fall, then rise together. Each delay is at least 1 cycle.
- R5: `ras_n` stays low for max(RAS cycles, CHR cycles + 1) cycles. It then stays high for at least max(RP cycles, RPC cycles) before the column strobes fall again. Whenever `ref_req` is 0, the strobes are all high.
- R6: A cycle starts (column strobes fall with `ras_n` high) only after a clock edge at which both `ref_req` and `ref_gnt` were 1. While the grant is low, no strobe moves.
- R7: Dropping `ref_gnt` after a cycle has started does not shorten or stop that cycle.
- R8: Refreshes owed while the grant is withheld accumulate while fewer than MISS_LIMIT are owed. Once the grant returns they are issued back to back with `ref_req` held high, and `miss` stays 0 and `ready` stays 1.
- R9: When the owed count would reach MISS_LIMIT, `miss` is 1 for exactly one cycle and `ready` is 0 in that same cycle. WAKE_COUNT wake-up cycles are then replayed before `ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller hands the strobes to the sequencer |
| ref_req | output | 1 | Sequencer has wake-up or refresh cycles owed |
| ready | output | 1 | Memory initialised and within its retention deadline |
| miss | output | 1 | One-cycle pulse: refresh deadline missed, wake-up replay follows |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes for both byte lanes, active low |

## Verification
The bench measures the exact pause length and the exact number of wake-up cycles. A design off by one in either would show a shifted `ref_req` rise or a `ready` that comes one cycle early or late. It drops the grant in the middle of a cycle and also withholds it across several intervals. This catches a design that truncates a started strobe pulse, that loses postponed refreshes, or that misses the deadline one tick early or late. It also replays wake-up after a deliberate miss and checks refresh spacing under a fully open grant. A randomly toggling grant then exercises every strobe width and setup rule against bench-side counters.

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer #(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_US     = 200,
  parameter int WAKE_COUNT   = 8,
  parameter int RETENTION_US = 16000,
  parameter int ROWS         = 1024,
  parameter int T_CSR_NS     = 10,
  parameter int T_CHR_NS     = 10,
  parameter int T_RAS_NS     = 50,
  parameter int T_RP_NS      = 30,
  parameter int T_RPC_NS     = 5,
  parameter int MISS_LIMIT   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_gnt,
  output logic       ref_req,
  output logic       ready,
  output logic       miss,
  output logic       ras_n,
  output logic [1:0] cas_n
);

  function automatic int ns2cyc(int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int INT_CYC   = RETENTION_US * CLK_MHZ / ROWS;
  localparam int CSR_CYC   = ns2cyc(T_CSR_NS);
  localparam int CHR_CYC   = ns2cyc(T_CHR_NS);
  localparam int RASL      = imax(ns2cyc(T_RAS_NS), CHR_CYC + 1);
  localparam int PRE_CYC   = imax(ns2cyc(T_RP_NS), ns2cyc(T_RPC_NS));
  localparam int PT_W      = $clog2(imax(imax(PAUSE_CYC, RASL), imax(CSR_CYC, PRE_CYC)) + 1);
  localparam int IT_W      = $clog2(INT_CYC + 1);
  localparam int WW        = $clog2(WAKE_COUNT + 1);
  localparam int OW        = $clog2(MISS_LIMIT + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CSR, S_RAS, S_PRE} state_t;

  state_t        state;
  logic [PT_W-1:0] tmr;
  logic [IT_W-1:0] itmr;
  logic [WW-1:0]   wake_left;
  logic [OW-1:0]   owed;
  logic            cyc_wake;
  logic            tick, start, fin, dec_owed, over;
  logic [OW:0]     owed_nx;

  assign tick     = ready && (itmr == IT_W'(INT_CYC - 1));
  assign start    = (state == S_IDLE) && ref_req && ref_gnt;
  assign fin      = (state == S_PRE) && (tmr == PT_W'(PRE_CYC - 1));
  assign dec_owed = fin && !cyc_wake && (owed != '0);
  assign owed_nx  = {1'b0, owed} + (OW+1)'(tick) - (OW+1)'(dec_owed);
  assign over     = (owed_nx == (OW+1)'(MISS_LIMIT));

  assign ref_req = (state != S_PAUSE) && ((wake_left != '0) || (owed != '0));
  assign ras_n   = (state != S_RAS);
  assign cas_n   = {2{!((state == S_CSR) || ((state == S_RAS) && (tmr < PT_W'(CHR_CYC))))}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_PAUSE;
      tmr       <= '0;
      itmr      <= '0;
      wake_left <= '0;
      owed      <= '0;
      cyc_wake  <= 1'b0;
      ready     <= 1'b0;
      miss      <= 1'b0;
    end else begin
      miss <= over;

      if (!ready || tick) itmr <= '0;
      else                itmr <= itmr + 1'b1;

      case (state)
        S_PAUSE: begin
          if (tmr == PT_W'(PAUSE_CYC - 1)) begin
            state     <= S_IDLE;
            tmr       <= '0;
            wake_left <= WW'(WAKE_COUNT);
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_IDLE: begin
          if (start) begin
            state    <= S_CSR;
            tmr      <= '0;
            cyc_wake <= (wake_left != '0);
          end
        end
        S_CSR: begin
          if (tmr == PT_W'(CSR_CYC - 1)) begin
            state <= S_RAS;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_RAS: begin
          if (tmr == PT_W'(RASL - 1)) begin
            state <= S_PRE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_PRE: begin
          if (fin) begin
            state <= S_IDLE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= S_PAUSE;
      endcase

      if (over) begin
        owed      <= '0;
        wake_left <= WW'(WAKE_COUNT);
        ready     <= 1'b0;
      end else begin
        owed <= owed_nx[OW-1:0];
        if (fin && cyc_wake) begin
          wake_left <= wake_left - 1'b1;
          if (wake_left == WW'(1)) ready <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int RASL = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_gnt,
  input logic       ref_req,
  input logic       ready,
  input logic       miss,
  input logic       ras_n,
  input logic [1:0] cas_n
);

  localparam int LW = $clog2(RASL + 1) + 1;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      lo_cnt <= '0;
    else if (!ras_n) lo_cnt <= lo_cnt + 1'b1;
    else             lo_cnt <= '0;
  end

  p_lanes_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n[0] == cas_n[1]);

  p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 2'b00) && (cas_n == 2'b00));

  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt == LW'(RASL)));

  p_quiet_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |-> (ras_n && (cas_n == 2'b11)));

  p_start_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && $fell(cas_n[0])) |-> $past(ref_gnt && ref_req));

  p_miss_clears_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !ready);

  p_miss_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);

  p_ready_after_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ras_n && !ref_req));

endmodule

bind dram_refresh_sequencer drs_checker #(.RASL(RASL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ready(ready), .miss(miss), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/dram_refresh_sequencer_test.sv
`timescale 1ns/1ps
module dram_refresh_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 100, PAUSE = 2, WAKE = 8, RET = 64, NROWS = 64;
  localparam int CSR_NS = 20, CHR_NS = 10, RAS_NS = 50, RP_NS = 30, RPC_NS = 5, LIMIT = 4;

  function automatic int up(int ns);
    int c;
    c = (ns * MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PAUSE = PAUSE * MHZ;
  localparam int E_INT   = RET * MHZ / NROWS;
  localparam int E_CSR   = up(CSR_NS);
  localparam int E_CHR   = up(CHR_NS);
  localparam int E_RASL  = mx(up(RAS_NS), E_CHR + 1);
  localparam int E_PRE   = mx(up(RP_NS), up(RPC_NS));

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ready, miss, ras_n;
  logic [1:0] cas_n;

  dram_refresh_sequencer #(
    .CLK_MHZ(MHZ), .PAUSE_US(PAUSE), .WAKE_COUNT(WAKE), .RETENTION_US(RET), .ROWS(NROWS),
    .T_CSR_NS(CSR_NS), .T_CHR_NS(CHR_NS), .T_RAS_NS(RAS_NS), .T_RP_NS(RP_NS),
    .T_RPC_NS(RPC_NS), .MISS_LIMIT(LIMIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready),
    .miss(miss), .ras_n(ras_n), .cas_n(cas_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int nfalls = 0, nmiss = 0;
  int pre_cnt = 0, ras_lo = 0, cas_hold = 0, gap = 1000, last_ras_lo = 0;
  logic prev_ras = 1, prev_cas = 1, gnt_edge = 0, req_edge = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    gnt_edge <= ref_gnt;
    req_edge <= ref_req;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cas_n[0] != cas_n[1]) chk(0, "R4 lanes differ", cas_n, 0);
      if (miss) nmiss++;
      if (prev_ras && !ras_n) begin
        chk(pre_cnt == E_CSR, "R4 column setup", pre_cnt, E_CSR);
        chk(cas_n == 2'b00, "R4 column low at row fall", cas_n, 0);
        nfalls++;
        ras_lo = 1;
        cas_hold = (cas_n[0] == 0) ? 1 : 0;
      end else if (!prev_ras && !ras_n) begin
        ras_lo++;
        if (cas_n[0] == 0) cas_hold++;
      end
      if (!prev_cas && cas_n[0] && !ras_n)
        chk(cas_hold == E_CHR, "R4 column hold", cas_hold, E_CHR);
      if (!prev_ras && ras_n) begin
        chk(ras_lo == E_RASL, "R5/R7 row low width", ras_lo, E_RASL);
        last_ras_lo = ras_lo;
        gap = 1;
      end else if (prev_ras && ras_n && cas_n[0]) begin
        gap++;
      end
      if (prev_cas && !cas_n[0] && ras_n) begin
        chk(gap >= E_PRE, "R5 precharge before next cycle", gap, E_PRE);
        chk(gnt_edge && req_edge, "R6 start without grant", gnt_edge, 1);
      end
      if (cas_n[0] == 0 && ras_n) pre_cnt++;
      else if (cas_n[0]) pre_cnt = 0;
      if (!ref_req && !(ras_n && cas_n == 2'b11)) chk(0, "R5 strobes idle without request", cas_n, 3);
      prev_ras = ras_n;
      prev_cas = cas_n[0];
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, 150000);
    report();
    $finish;
  end

  task automatic wait_fall(output int t);
    int n;
    n = nfalls;
    while (nfalls == n) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    int k, f0, t0, t1, seed;
    bit seen;
    seed = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ras_n === 1'b1 && cas_n === 2'b11, "R1 strobes idle in reset", {ras_n, cas_n}, 7);
    chk(ready === 1'b0 && ref_req === 1'b0 && miss === 1'b0, "R1 flags low in reset",
        {ready, ref_req, miss}, 0);
    rst_n = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!ref_req && k < 10 * E_PAUSE);
    chk(k == E_PAUSE, "R1 pause length", k, E_PAUSE);
    chk(ready == 0, "R2 not ready before wake-up", ready, 0);
    // R6 no movement while grant low
    f0 = nfalls;
    repeat (50) @(negedge clk);
    chk(nfalls == f0 && cas_n == 2'b11, "R6 no cycle without grant", nfalls - f0, 0);
    // R2 wake-up count
    ref_gnt = 1;
    while (!ready) @(negedge clk);
    chk(nfalls - f0 == WAKE, "R2 wake-up cycles", nfalls - f0, WAKE);
    // R3 spacing
    wait_fall(t0);
    for (int i = 0; i < 3; i++) begin
      wait_fall(t1);
      chk(t1 - t0 == E_INT, "R3 refresh spacing", t1 - t0, E_INT);
      t0 = t1;
    end
    // R7 grant drop mid-cycle
    wait_fall(t0);
    @(negedge clk);
    ref_gnt = 0;
    while (!ras_n) @(negedge clk);
    chk(last_ras_lo == E_RASL, "R7 cycle completes after grant drop", last_ras_lo, E_RASL);
    ref_gnt = 1;
    // R8 postponed refreshes
    while (ref_req) @(negedge clk);
    ref_gnt = 0;
    repeat (250) @(negedge clk);
    chk(ref_req == 1 && ready == 1 && nmiss == 0, "R8 owed without miss", {ref_req, ready}, 3);
    f0 = nfalls;
    ref_gnt = 1;
    k = 0;
    while (ref_req && k < 1000) begin @(negedge clk); k++; end
    chk(nfalls - f0 >= 2 && nfalls - f0 <= 3, "R8 burst of owed refreshes", nfalls - f0, 2);
    chk(ready == 1 && nmiss == 0, "R8 ready kept", ready, 1);
    // R9 deadline miss
    while (ref_req) @(negedge clk);
    ref_gnt = 0;
    k = 0;
    seen = 0;
    while (!seen && k < (LIMIT + 2) * E_INT) begin
      @(negedge clk); k++;
      if (miss) seen = 1;
    end
    chk(seen, "R9 miss flagged", seen, 1);
    chk(k > (LIMIT - 1) * E_INT && k <= LIMIT * E_INT, "R9 miss timing", k, LIMIT * E_INT);
    chk(ready == 0, "R9 ready dropped with miss", ready, 0);
    @(negedge clk);
    chk(miss == 0, "R9 miss single pulse", miss, 0);
    f0 = nfalls;
    ref_gnt = 1;
    while (!ready) @(negedge clk);
    chk(nfalls - f0 == WAKE, "R9 wake-up replay", nfalls - f0, WAKE);
    // random grant
    nmiss = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ref_gnt = ($urandom % 4) != 0;
    end
    ref_gnt = 1;
    repeat (50) @(negedge clk);
    chk(nmiss == 0 && ready == 1, "R8 random grant keeps deadline", nmiss, 0);
    report();
    $finish;
  end
endmodule